// File: doc/BRIEF.md
# Daisy-Chain Address Enumerator

This block is the control layer above a byte-level I2C master engine. It numbers the slaves of a daisy chain in which each node passes the bus on to its downstream neighbour only once it has been given an address. Every node powers up answering the shared listen address 0xAA. The sequencer writes an address value to that listen address. The one node that can see the bus takes the value as its own address and then opens the bus to the next node. The sequencer repeats this, adding one to the value at each step, until a write goes unacknowledged. The number of acknowledged steps is the slave count, and the value each node holds also gives its physical position along the chain.

A second mode walks the addresses handed out by the last enumeration, from the nearest node to the farthest. It reports the first one that no longer answers, which shows where the chain is broken. The sequencer talks to the bit-level engine one command at a time: start condition, byte write, or stop condition. It waits for the engine to finish each command and report the ACK bit before it issues the next.

Top module: `chain_enum_master`

## Requirements
- R1: Each enumeration step is one frame of four engine commands, issued in this order: START (cmd_op=0), WRITE (cmd_op=1) of address byte 0xAA, WRITE of the value being assigned, STOP (cmd_op=2). cmd_byte carries the byte for a WRITE and is 0 for START and STOP.
- R2: The value assigned in the first step is 0x0F, and each following step assigns one more than the step before it.
- R3: Enumeration ends at the first step in which the address byte or the data byte is not acknowledged. A STOP still closes that frame, the data byte is skipped if the address byte was refused, and slave_count equals the number of fully acknowledged steps.
- R4: Once MAX_SLAVES steps have been acknowledged, enumeration stops without a further step. overflow goes to 1 and slave_count equals MAX_SLAVES.
- R5: With mode=1 (locate), the sequencer polls the addresses 0x0F up to 0x0F+slave_count-1 in increasing order. Each poll is a frame of START, WRITE of the address, WRITE of 0x00, STOP. At the first refused byte it closes the frame with STOP, stops, and sets fault_found=1 with fault_addr equal to the polled address.
- R6: A locate run in which every poll is acknowledged, or in which slave_count is 0, ends with fault_found=0 and fault_addr=0. With slave_count of 0 it issues no command at all.
- R7: cmd_valid is raised only while eng_busy is low and never in two consecutive cycles. After each command the sequencer waits for eng_done before it issues the next.
- R8: busy is high from the cycle after an accepted start until done. done is a single-cycle pulse. slave_count, overflow, fault_found and fault_addr do not change while the block is idle and no start is given. A locate run leaves slave_count and overflow as they were.
- R9: A start pulse that arrives while busy is high has no effect: neither the command stream nor the results change.
- R10: After reset, busy, done, cmd_valid, overflow and fault_found are 0, and slave_count and fault_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run; taken only when idle |
| mode | input | 1 | 0 = enumerate, 1 = locate break; sampled with start |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| slave_count | output | CNT_W (5) | Number of slaves found by the last enumeration |
| overflow | output | 1 | Enumeration stopped at MAX_SLAVES |
| fault_found | output | 1 | Last locate run found a silent node |
| fault_addr | output | 8 | Address of the first silent node, 0 if none |
| cmd_valid | output | 1 | Command strobe to the engine |
| cmd_op | output | 2 | 0 START, 1 WRITE, 2 STOP |
| cmd_byte | output | 8 | Byte for a WRITE command |
| eng_busy | input | 1 | Engine is carrying out a command |
| eng_done | input | 1 | One-cycle pulse: command finished |
| eng_ack | input | 1 | ACK result of the finished WRITE, valid with eng_done |

## Verification
Assertions check the engine handshake on every cycle: one command per strobe, none while the engine is busy, and none before the previous command is done. They also check that done is a pulse, that the results stay put while idle, that the count never passes its cap and matches it whenever overflow is set, and that the mode cannot change mid-run. Only the bench scenarios can show the order and content of the frames and the point where the chain ends. These include a chain refusing a data byte, a chain longer than the cap, and breaks found by locate. The bench's engine answers from a model of nodes that join the bus one by one.

// File: rtl/chain_enum_pkg.sv
package chain_enum_pkg;

    localparam logic [7:0] LISTEN_BYTE = 8'hAA;
    localparam logic [7:0] FIRST_ADDR  = 8'h0F;
    localparam logic [7:0] POLL_DATA   = 8'h00;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_STOP  = 2'd2
    } cmd_op_e;

    typedef enum logic {
        MODE_ENUM   = 1'b0,
        MODE_LOCATE = 1'b1
    } mode_e;

    typedef enum logic [1:0] {C_IDLE, C_LAUNCH, C_WAIT, C_FIN} ctrl_st_e;
    typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} frame_st_e;
    typedef enum logic [1:0] {PH_START, PH_ADDR, PH_DATA, PH_STOP} phase_e;

    typedef struct packed {
        cmd_op_e    op;
        logic [7:0] data;
    } cmd_t;

    function automatic logic [7:0] addr_of(input logic [7:0] idx);
        return FIRST_ADDR + idx;
    endfunction

endpackage

// File: rtl/chain_enum_frame.sv
module chain_enum_frame
    import chain_enum_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] addr_byte,
    input  logic [7:0] data_byte,
    input  logic       eng_busy,
    input  logic       eng_done,
    input  logic       eng_ack,
    output logic       cmd_valid,
    output cmd_t       cmd,
    output logic       frame_done,
    output logic       frame_acked,
    output logic       frame_active
);

    frame_st_e  fst;
    phase_e     ph;
    logic [7:0] addr_q;
    logic [7:0] data_q;

    always_comb begin
        cmd_valid    = (fst == F_ISSUE) && !eng_busy;
        frame_active = (fst != F_IDLE);
        case (ph)
            PH_START: cmd = '{op: OP_START, data: 8'h00};
            PH_ADDR:  cmd = '{op: OP_WRITE, data: addr_q};
            PH_DATA:  cmd = '{op: OP_WRITE, data: data_q};
            default:  cmd = '{op: OP_STOP,  data: 8'h00};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fst         <= F_IDLE;
            ph          <= PH_START;
            addr_q      <= '0;
            data_q      <= '0;
            frame_done  <= 1'b0;
            frame_acked <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (fst)
                F_IDLE: if (go) begin
                    addr_q      <= addr_byte;
                    data_q      <= data_byte;
                    ph          <= PH_START;
                    frame_acked <= 1'b1;
                    fst         <= F_ISSUE;
                end
                F_ISSUE: if (!eng_busy) fst <= F_WAIT;
                default: if (eng_done) begin
                    fst <= F_ISSUE;
                    case (ph)
                        PH_START: ph <= PH_ADDR;
                        PH_ADDR: begin
                            if (!eng_ack) begin
                                frame_acked <= 1'b0;
                                ph          <= PH_STOP;
                            end else begin
                                ph <= PH_DATA;
                            end
                        end
                        PH_DATA: begin
                            if (!eng_ack) frame_acked <= 1'b0;
                            ph <= PH_STOP;
                        end
                        default: begin
                            fst        <= F_IDLE;
                            frame_done <= 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end

    // R7: one strobe per command, never back to back
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R7: no new command while the previous one is unfinished
    a_r7_wait_done: assert property (@(posedge clk) disable iff (rst)
        (fst == F_WAIT && !eng_done) |=> !cmd_valid);

    // R1: a frame is only launched when the previous one has closed
    a_r1_go_when_idle: assert property (@(posedge clk) disable iff (rst)
        go |-> !frame_active);

endmodule

// File: rtl/chain_enum_ctrl.sv
module chain_enum_ctrl
    import chain_enum_pkg::*;
#(
    parameter int MAX_SLAVES = 30,
    parameter int CNT_W      = $clog2(MAX_SLAVES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode,
    input  logic             frame_done,
    input  logic             frame_acked,
    input  logic             frame_active,
    output logic             frame_go,
    output logic [7:0]       frame_addr,
    output logic [7:0]       frame_data,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] slave_count,
    output logic             overflow,
    output logic             fault_found,
    output logic [7:0]       fault_addr
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_SLAVES);

    ctrl_st_e         st;
    mode_e            mode_q;
    logic [CNT_W-1:0] poll_idx;
    logic             poll_end;

    always_comb begin
        poll_end   = (mode_q == MODE_LOCATE) && (poll_idx == slave_count);
        frame_go   = (st == C_LAUNCH) && !poll_end;
        frame_addr = (mode_q == MODE_LOCATE) ? addr_of(8'(poll_idx)) : LISTEN_BYTE;
        frame_data = (mode_q == MODE_LOCATE) ? POLL_DATA : addr_of(8'(slave_count));
        busy       = (st != C_IDLE);
        done       = (st == C_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= C_IDLE;
            mode_q      <= MODE_ENUM;
            poll_idx    <= '0;
            slave_count <= '0;
            overflow    <= 1'b0;
            fault_found <= 1'b0;
            fault_addr  <= '0;
        end else begin
            case (st)
                C_IDLE: if (start) begin
                    mode_q      <= mode_e'(mode);
                    poll_idx    <= '0;
                    fault_found <= 1'b0;
                    fault_addr  <= '0;
                    if (mode_e'(mode) == MODE_ENUM) begin
                        slave_count <= '0;
                        overflow    <= 1'b0;
                    end
                    st <= C_LAUNCH;
                end
                C_LAUNCH: st <= poll_end ? C_FIN : C_WAIT;
                C_WAIT: if (frame_done) begin
                    if (mode_q == MODE_ENUM) begin
                        if (frame_acked) begin
                            slave_count <= slave_count + 1'b1;
                            if (slave_count + 1'b1 == MAX_C) begin
                                overflow <= 1'b1;
                                st       <= C_FIN;
                            end else begin
                                st <= C_LAUNCH;
                            end
                        end else begin
                            st <= C_FIN;
                        end
                    end else begin
                        if (frame_acked) begin
                            poll_idx <= poll_idx + 1'b1;
                            st       <= C_LAUNCH;
                        end else begin
                            fault_found <= 1'b1;
                            fault_addr  <= addr_of(8'(poll_idx));
                            st          <= C_FIN;
                        end
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    // R4: the count never passes the cap
    a_r4_count_cap: assert property (@(posedge clk) disable iff (rst)
        slave_count <= MAX_C);

    // R4: overflow only with a full count
    a_r4_overflow_full: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (slave_count == MAX_C));

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: results hold while idle
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(slave_count) && $stable(overflow)
                               && $stable(fault_found) && $stable(fault_addr)));

    // R9: a run's mode cannot be changed by a late start
    a_r9_mode_locked: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q));

    // R1: a frame is requested only while the frame unit is free
    a_r1_frame_free: assert property (@(posedge clk) disable iff (rst)
        (st == C_WAIT && !frame_done) |-> frame_active);

endmodule

// File: rtl/chain_enum_master.sv
module chain_enum_master
    import chain_enum_pkg::*;
#(
    parameter int MAX_SLAVES = 30,
    parameter int CNT_W      = $clog2(MAX_SLAVES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] slave_count,
    output logic             overflow,
    output logic             fault_found,
    output logic [7:0]       fault_addr,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_byte,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  logic             eng_ack
);

    logic       frame_go;
    logic [7:0] frame_addr;
    logic [7:0] frame_data;
    logic       frame_done;
    logic       frame_acked;
    logic       frame_active;
    cmd_t       cmd;

    chain_enum_ctrl #(
        .MAX_SLAVES (MAX_SLAVES),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .mode         (mode),
        .frame_done   (frame_done),
        .frame_acked  (frame_acked),
        .frame_active (frame_active),
        .frame_go     (frame_go),
        .frame_addr   (frame_addr),
        .frame_data   (frame_data),
        .busy         (busy),
        .done         (done),
        .slave_count  (slave_count),
        .overflow     (overflow),
        .fault_found  (fault_found),
        .fault_addr   (fault_addr)
    );

    chain_enum_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .go           (frame_go),
        .addr_byte    (frame_addr),
        .data_byte    (frame_data),
        .eng_busy     (eng_busy),
        .eng_done     (eng_done),
        .eng_ack      (eng_ack),
        .cmd_valid    (cmd_valid),
        .cmd          (cmd),
        .frame_done   (frame_done),
        .frame_acked  (frame_acked),
        .frame_active (frame_active)
    );

    assign cmd_op   = cmd.op;
    assign cmd_byte = cmd.data;

endmodule

// File: tb/chain_enum_master_bench.sv
module chain_enum_master_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAXS       = 30;
    localparam int CW         = $clog2(MAXS + 1);
    localparam int NODES      = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic          busy, done, overflow, fault_found, cmd_valid;
    logic [CW-1:0] slave_count;
    logic [7:0]    fault_addr, cmd_byte;
    logic [1:0]    cmd_op;
    logic          eng_busy, eng_done, eng_ack;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;

    chain_enum_master #(.MAX_SLAVES(MAXS)) u_chain_enum_master (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .busy(busy), .done(done), .slave_count(slave_count),
        .overflow(overflow), .fault_found(fault_found), .fault_addr(fault_addr),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_ack(eng_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- chain of nodes answering the engine ----------------
    bit       joined [NODES];
    bit [7:0] held   [NODES];
    int       n_nodes, brk, nack_data_at;
    int       bidx, target;
    bit [7:0] last_addr;
    bit       hit;
    bit       a_now;
    bit       pend_ack;
    int       cd;
    string    cur_req = "R1";
    bit [9:0] exp_q [$];

    function automatic bit reach(int j);
        if (j >= n_nodes || j >= brk) return 1'b0;
        for (int i = 0; i < j; i++) if (!joined[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic power_cycle(input int n, input int nack_at);
        n_nodes = n; nack_data_at = nack_at; brk = 1000;
        for (int i = 0; i < NODES; i++) begin joined[i] = 1'b0; held[i] = 8'h00; end
    endtask

    task automatic node_cmd(input bit [1:0] op, input bit [7:0] b, output bit ack);
        ack = 1'b1;
        if (op == 2'd0) bidx = 0;
        else if (op == 2'd1) begin
            if (bidx == 0) begin
                last_addr = b; target = -1; hit = 1'b0;
                if (b == 8'hAA) begin
                    for (int j = 0; j < NODES; j++)
                        if (target < 0 && !joined[j] && reach(j)) target = j;
                    ack = (target >= 0);
                end else begin
                    for (int j = 0; j < NODES; j++)
                        if (joined[j] && reach(j) && held[j] == b) hit = 1'b1;
                    ack = hit;
                end
            end else begin
                if (last_addr == 8'hAA) begin
                    ack = (target >= 0) && (target != nack_data_at);
                    if (ack) begin joined[target] = 1'b1; held[target] = b; end
                end else ack = hit;
            end
            bidx++;
        end
    endtask

    // engine model: busy two cycles, then a done pulse with the ACK
    always @(posedge clk) begin
        if (rst) begin
            eng_busy <= 1'b0; eng_done <= 1'b0; eng_ack <= 1'b0; cd <= 0;
        end else begin
            eng_done <= 1'b0;
            if (cmd_valid) begin
                if (exp_q.size() == 0)
                    check(1'b0, cur_req, "unexpected command", {cmd_op, cmd_byte}, 0);
                else begin
                    automatic bit [9:0] e = exp_q.pop_front();
                    check({cmd_op, cmd_byte} == e, cur_req, "command op/byte",
                          {cmd_op, cmd_byte}, e);
                end
                node_cmd(cmd_op, cmd_byte, a_now);
                pend_ack <= a_now;
                eng_busy <= 1'b1;
                cd <= 2;
            end else if (eng_busy) begin
                if (cd == 1) begin
                    eng_busy <= 1'b0; eng_done <= 1'b1; eng_ack <= pend_ack;
                end else cd <= cd - 1;
            end
        end
    end

    // ---------------- per-clock reference checks ----------------
    bit            p_busy, p_done, p_cv;
    bit [CW-1:0]   p_cnt;
    bit            p_ovf, p_ff;
    bit [7:0]      p_fa;

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        cycles++;
        if (cycles > 100000) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
        if (!rst) begin
            check(!(p_done && done), "R8", "done wider than one cycle", 1, 0);
            check(!(cmd_valid && p_cv), "R7", "back-to-back cmd_valid", 1, 0);
            check(!(cmd_valid && eng_busy), "R7", "cmd_valid while engine busy", 1, 0);
            if (!p_busy && !start)
                check(slave_count == p_cnt && overflow == p_ovf &&
                      fault_found == p_ff && fault_addr == p_fa,
                      "R8", "results moved while idle", slave_count, p_cnt);
        end
        p_busy = busy; p_done = done; p_cv = cmd_valid;
        p_cnt = slave_count; p_ovf = overflow; p_ff = fault_found; p_fa = fault_addr;
    end

    // ---------------- expected streams ----------------
    int e_count, e_faddr;
    bit e_ovf, e_ff;

    function automatic bit [9:0] ent(input int op, input int b);
        return {2'(op), 8'(b)};
    endfunction

    task automatic expect_enum(input int n, input int nack_at);
        automatic int k = 0;
        e_ovf = 1'b0; e_ff = 1'b0; e_faddr = 0;
        while (1) begin
            if (k == MAXS) begin e_ovf = 1'b1; break; end
            exp_q.push_back(ent(0, 0));
            exp_q.push_back(ent(1, 8'hAA));
            if (k < n) begin
                exp_q.push_back(ent(1, 8'h0F + k));
                exp_q.push_back(ent(2, 0));
                if (k == nack_at) break;
                k++;
            end else begin
                exp_q.push_back(ent(2, 0));
                break;
            end
        end
        e_count = k;
    endtask

    task automatic expect_locate(input int cnt, input int brk_at);
        e_ff = 1'b0; e_faddr = 0;
        for (int i = 0; i < cnt; i++) begin
            exp_q.push_back(ent(0, 0));
            exp_q.push_back(ent(1, 8'h0F + i));
            if (i < brk_at) begin
                exp_q.push_back(ent(1, 0));
                exp_q.push_back(ent(2, 0));
            end else begin
                exp_q.push_back(ent(2, 0));
                e_ff = 1'b1; e_faddr = 8'h0F + i;
                break;
            end
        end
    endtask

    task automatic run(input bit m, input string req, input int late_start);
        cur_req = req;
        @(negedge clk); mode = m; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R8", "busy after accepted start", busy, 1);
        for (int c = 0; c < 20000; c++) begin
            if (done) break;
            @(negedge clk);
            if (c == late_start && busy) begin mode = ~m; start = 1'b1; end
            else start = 1'b0;
        end
        start = 1'b0;
        check(done == 1'b1, req, "done reached", done, 1);
        check(slave_count == e_count, req, "slave_count", slave_count, e_count);
        check(overflow == e_ovf, req, "overflow", overflow, e_ovf);
        check(fault_found == e_ff, req, "fault_found", fault_found, e_ff);
        check(fault_addr == e_faddr, req, "fault_addr", fault_addr, e_faddr);
        check(exp_q.size() == 0, req, "commands left unissued", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R8", "idle after done", busy, 0);
    endtask

    initial begin
        power_cycle(0, -1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!busy && !done && !cmd_valid, "R10", "control outputs", {busy, done, cmd_valid}, 0);
        check(slave_count == 0 && !overflow, "R10", "count/overflow", slave_count, 0);
        check(!fault_found && fault_addr == 0, "R10", "fault outputs", fault_addr, 0);

        // R1 R2 R3: three nodes; a late locate start must be ignored (R9)
        power_cycle(3, -1); expect_enum(3, -1);
        run(1'b0, "R1/R2/R9", 6);

        // R6: every node answers
        expect_locate(3, 99);
        run(1'b1, "R6", -1);

        // R5: chain broken after the first node
        brk = 1; expect_locate(3, 1);
        run(1'b1, "R5", -1);

        // R3: empty chain
        power_cycle(0, -1); expect_enum(0, -1);
        run(1'b0, "R3", -1);

        // R6: locate with nothing enumerated issues no command
        expect_locate(0, 99);
        run(1'b1, "R6", -1);

        // R3: third node refuses its data byte
        power_cycle(5, 2); expect_enum(5, 2);
        run(1'b0, "R3", 10);

        // R4: chain longer than the cap
        power_cycle(32, -1); expect_enum(32, -1);
        run(1'b0, "R4", -1);

        // R5 + R8: break near the middle, overflow and count stay
        brk = 10; expect_locate(MAXS, 10); e_ovf = 1'b1; e_count = MAXS;
        run(1'b1, "R5/R8", -1);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule